// File: doc/BRIEF.md
# Speed-tracking transmit clock selector

This block chooses which of three free-running reference clocks (125 MHz, 25 MHz and 2.5 MHz) drives an Ethernet transmitter. The choice follows the link speed that the receive path reports. The speed flags and the link-up flag arrive from the receive clock domain. The block synchronizes them into the system clock domain and accepts a new speed only after it has held steady for a programmable number of cycles. It then performs a glitch-free changeover. During the changeover it holds the transmitter in reset: it stops the old clock, waits for the slowest clock to finish, starts the new clock and lets it run for a settling period.

The block also holds the transmitter in reset whenever the synchronized link flag is low. A link that is down never triggers a changeover. Its outputs are the gated transmit clock, the transmit reset, one-hot speed flags, a registered link flag and a flag that is high during a changeover. The gigabit speed flag chooses between DDR and SDR data handling downstream.

Timing constants are counted in system clock cycles. SLOW_RATIO is the number of system cycles in one period of the 2.5 MHz clock. The gate-off wait is OFF_WAIT = (3+2)·SLOW_RATIO: three periods of gate lag plus two idle periods. The gate-on wait is ON_WAIT = (3+SETTLE_CLKS)·SLOW_RATIO: three periods of gate lag plus SETTLE_CLKS settling periods. With the defaults these are 100 and 220 cycles.

Top module: `txclk_select`

## Requirements
- R1: The speed outputs are always exactly one-hot. The clock chosen by each speed is: 10 Mb selects clk_2p5 (tx_spd_10), 100 Mb selects clk_25 (tx_spd_100), gigabit selects clk_125 (tx_spd_1000). After reset the selection is gigabit.
- R2: Every status input passes through a two-flop synchronizer. link_up equals rx_link as sampled three system clock edges earlier.
- R3: A new speed takes effect only after it has been present on the synchronized flags for more than STABLE_CYCLES consecutive system cycles. Shorter excursions cause no changeover.
- R4: A speed input pattern with zero or more than one flag set is ignored. It causes no changeover and the selection is kept.
- R5: rst_tx is high whenever changing is high or the synchronized link is down. Otherwise it is low.
- R6: While the synchronized link is down, no changeover starts and the speed selection is unchanged.
- R7: A changeover starts when a valid, stable speed differs from the current one and the link is up. changing then stays high for exactly OFF_WAIT+ON_WAIT cycles. The speed outputs switch OFF_WAIT cycles after changing rises. At most one reference clock gate is open at any time.
- R8: clk_tx never shows a high or low phase shorter than half a period of the 125 MHz clock.
- R9: After a changeover completes, clk_tx runs at the period of the newly selected reference clock.
- R10: During reset, rst_tx is 1, changing is 0, link_up is 0 and tx_spd_1000 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_125 | input | 1 | 125 MHz reference clock |
| clk_25 | input | 1 | 25 MHz reference clock |
| clk_2p5 | input | 1 | 2.5 MHz reference clock |
| rx_spd_10 | input | 1 | Receive-domain 10 Mb flag |
| rx_spd_100 | input | 1 | Receive-domain 100 Mb flag |
| rx_spd_1000 | input | 1 | Receive-domain gigabit flag |
| rx_link | input | 1 | Receive-domain link-up flag |
| clk_tx | output | 1 | Gated transmit clock |
| rst_tx | output | 1 | Transmitter reset |
| tx_spd_10 | output | 1 | 10 Mb selected |
| tx_spd_100 | output | 1 | 100 Mb selected |
| tx_spd_1000 | output | 1 | Gigabit selected (DDR mode) |
| link_up | output | 1 | Synchronized link flag |
| changing | output | 1 | Changeover in progress |

## Verification
The hardest case to reach from the ports is the boundary of the debounce window crossed while the link state also matters. A speed excursion that is one cycle too short must be ignored. A stable new speed that arrives while the link is down must be kept pending and acted on only once the link returns. The stimulus drives short speed pulses, invalid multi-flag patterns and a long speed change with the link held down. A cycle-accurate behavioural model compares every output on every system cycle. The real clock edges of clk_tx are also timed to catch runt phases and to confirm each new period.

// File: rtl/txclk_pkg.sv
`timescale 1ns/1ps
package txclk_pkg;
  typedef enum logic [1:0] {
    SPD_10   = 2'd0,
    SPD_100  = 2'd1,
    SPD_1000 = 2'd2,
    SPD_NONE = 2'd3
  } spd_code_e;

  typedef enum logic [1:0] {
    PH_RUN = 2'd0,
    PH_OFF = 2'd1,
    PH_ON  = 2'd2
  } phase_e;

  // flags: bit0 = 10 Mb, bit1 = 100 Mb, bit2 = gigabit
  function automatic spd_code_e decode_flags(input logic [2:0] flags);
    case (flags)
      3'b001:  return SPD_10;
      3'b010:  return SPD_100;
      3'b100:  return SPD_1000;
      default: return SPD_NONE;
    endcase
  endfunction

  function automatic logic [2:0] code_onehot(input spd_code_e code);
    case (code)
      SPD_10:   return 3'b001;
      SPD_100:  return 3'b010;
      default:  return 3'b100;
    endcase
  endfunction
endpackage

// File: rtl/txclk_sync.sv
`timescale 1ns/1ps
module txclk_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d_async;
      stage2 <= stage1;
    end
  end

  assign d_sync = stage2;
endmodule

// File: rtl/txclk_debounce.sv
`timescale 1ns/1ps
module txclk_debounce
  import txclk_pkg::*;
#(
  parameter int STABLE_CYCLES = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  spd_code_e code_in,
  output logic      steady
);
  localparam int SW = (STABLE_CYCLES > 2) ? $clog2(STABLE_CYCLES) : 1;
  localparam logic [SW-1:0] LAST = SW'(STABLE_CYCLES - 1);

  spd_code_e       last_code;
  logic [SW-1:0]   hold_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_code <= SPD_NONE;
      hold_cnt  <= '0;
    end else if (code_in != last_code) begin
      last_code <= code_in;
      hold_cnt  <= '0;
    end else if (hold_cnt != LAST) begin
      hold_cnt  <= hold_cnt + 1'b1;
    end
  end

  assign steady = (code_in == last_code) && (hold_cnt == LAST);
endmodule

// File: rtl/txclk_gate.sv
`timescale 1ns/1ps
module txclk_gate #(
  parameter bit INIT_ON = 1'b0
) (
  input  logic clk_ref,
  input  logic rst,
  input  logic enable,
  output logic gate_open,
  output logic clk_out
);
  logic en_meta;
  logic en_q;

  // Enable is retimed on the falling edge so it changes only while clk_ref is low.
  always_ff @(negedge clk_ref) begin
    if (rst) begin
      en_meta <= INIT_ON;
      en_q    <= INIT_ON;
    end else begin
      en_meta <= enable;
      en_q    <= en_meta;
    end
  end

  assign gate_open = en_q;
  assign clk_out   = clk_ref & en_q;
endmodule

// File: rtl/txclk_seq.sv
`timescale 1ns/1ps
module txclk_seq
  import txclk_pkg::*;
#(
  parameter int        OFF_WAIT = 100,
  parameter int        ON_WAIT  = 220,
  parameter spd_code_e INIT_SEL = SPD_1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       link_s,
  input  spd_code_e  code_s,
  input  logic       steady,
  output logic [2:0] gate_en,
  output logic [2:0] spd_q,
  output logic       rst_tx_q,
  output logic       chg_q,
  output logic       link_q
);
  localparam int MAXW = (OFF_WAIT > ON_WAIT) ? OFF_WAIT : ON_WAIT;
  localparam int CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_WAIT - 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_WAIT - 1);

  phase_e        phase, phase_n;
  spd_code_e     sel, sel_n, tgt, tgt_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [2:0]    gate_n;

  always_comb begin
    phase_n = phase;
    sel_n   = sel;
    tgt_n   = tgt;
    cnt_n   = cnt;
    gate_n  = gate_en;
    unique case (phase)
      PH_RUN: begin
        if (link_s && steady && (code_s != SPD_NONE) && (code_s != sel)) begin
          phase_n = PH_OFF;
          tgt_n   = code_s;
          cnt_n   = '0;
          gate_n  = 3'b000;
        end
      end
      PH_OFF: begin
        if (cnt == OFF_LAST) begin
          phase_n = PH_ON;
          sel_n   = tgt;
          cnt_n   = '0;
          gate_n  = code_onehot(tgt);
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      PH_ON: begin
        if (cnt == ON_LAST) begin
          phase_n = PH_RUN;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      default: phase_n = PH_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_RUN;
      sel      <= INIT_SEL;
      tgt      <= INIT_SEL;
      cnt      <= '0;
      gate_en  <= code_onehot(INIT_SEL);
      spd_q    <= code_onehot(INIT_SEL);
      rst_tx_q <= 1'b1;
      chg_q    <= 1'b0;
      link_q   <= 1'b0;
    end else begin
      phase    <= phase_n;
      sel      <= sel_n;
      tgt      <= tgt_n;
      cnt      <= cnt_n;
      gate_en  <= gate_n;
      spd_q    <= code_onehot(sel_n);
      rst_tx_q <= (phase_n != PH_RUN) || !link_s;
      chg_q    <= (phase_n != PH_RUN);
      link_q   <= link_s;
    end
  end
endmodule

// File: rtl/txclk_select.sv
`timescale 1ns/1ps
module txclk_select
  import txclk_pkg::*;
#(
  parameter int STABLE_CYCLES = 16,
  parameter int SLOW_RATIO    = 20,
  parameter int SETTLE_CLKS   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_125,
  input  logic clk_25,
  input  logic clk_2p5,
  input  logic rx_spd_10,
  input  logic rx_spd_100,
  input  logic rx_spd_1000,
  input  logic rx_link,
  output logic clk_tx,
  output logic rst_tx,
  output logic tx_spd_10,
  output logic tx_spd_100,
  output logic tx_spd_1000,
  output logic link_up,
  output logic changing
);
  localparam int GATE_LAG = 3;
  localparam int OFF_WAIT = (GATE_LAG + 2) * SLOW_RATIO;
  localparam int ON_WAIT  = (GATE_LAG + SETTLE_CLKS) * SLOW_RATIO;
  localparam int NCLK     = 3;
  localparam spd_code_e INIT_SEL = SPD_1000;
  localparam logic [NCLK-1:0] INIT_GATES = code_onehot(INIT_SEL);

  logic [3:0]      status_s;
  spd_code_e       code_s;
  logic            steady;
  logic [NCLK-1:0] gate_en;
  logic [NCLK-1:0] gate_on;
  logic [NCLK-1:0] gclk;
  logic [NCLK-1:0] ref_clk;
  logic [2:0]      spd_q;

  assign ref_clk = {clk_125, clk_25, clk_2p5};

  txclk_sync #(.WIDTH(4)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({rx_link, rx_spd_1000, rx_spd_100, rx_spd_10}),
    .d_sync  (status_s)
  );

  assign code_s = decode_flags(status_s[2:0]);

  txclk_debounce #(.STABLE_CYCLES(STABLE_CYCLES)) u_deb (
    .clk     (clk),
    .rst     (rst),
    .code_in (code_s),
    .steady  (steady)
  );

  txclk_seq #(
    .OFF_WAIT (OFF_WAIT),
    .ON_WAIT  (ON_WAIT),
    .INIT_SEL (INIT_SEL)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .link_s   (status_s[3]),
    .code_s   (code_s),
    .steady   (steady),
    .gate_en  (gate_en),
    .spd_q    (spd_q),
    .rst_tx_q (rst_tx),
    .chg_q    (changing),
    .link_q   (link_up)
  );

  for (genvar i = 0; i < NCLK; i++) begin : g_gate
    txclk_gate #(.INIT_ON(INIT_GATES[i])) u_gate (
      .clk_ref   (ref_clk[i]),
      .rst       (rst),
      .enable    (gate_en[i]),
      .gate_open (gate_on[i]),
      .clk_out   (gclk[i])
    );
  end

  assign clk_tx      = |gclk;
  assign tx_spd_10   = spd_q[0];
  assign tx_spd_100  = spd_q[1];
  assign tx_spd_1000 = spd_q[2];
endmodule

// File: rtl/txclk_select_chk.sv
`timescale 1ns/1ps
module txclk_select_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] spd,
  input logic       rst_tx,
  input logic       changing,
  input logic       link_up,
  input logic [2:0] gate_on
);
  // R1: speed outputs one-hot
  assert_onehot_speed_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(spd) == 1);

  // R5: reset held during changeover
  assert_rst_in_change_R5: assert property (@(posedge clk) disable iff (rst)
    changing |-> rst_tx);

  // R5: reset held while link down
  assert_rst_link_down_R5: assert property (@(posedge clk) disable iff (rst)
    !link_up |-> rst_tx);

  // R7: speed only moves inside a changeover
  assert_spd_moves_in_change_R7: assert property (@(posedge clk) disable iff (rst)
    (spd != $past(spd)) |-> changing);

  // R6: no selection change starts from a down link
  assert_hold_link_down_R6: assert property (@(posedge clk) disable iff (rst)
    (!link_up && !changing) |=> $stable(spd));

  // R7: never two gates open
  assert_gate_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gate_on));
endmodule

bind txclk_select txclk_select_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .spd      ({tx_spd_1000, tx_spd_100, tx_spd_10}),
  .rst_tx   (rst_tx),
  .changing (changing),
  .link_up  (link_up),
  .gate_on  (gate_on)
);

// File: tb/test_txclk_select.sv
`timescale 1ns/1ps
module test_txclk_select;
  localparam int  CLK_PERIOD = 20;
  localparam int  STABLE     = 16;
  localparam int  RATIO      = 20;
  localparam int  SETTLE     = 8;
  localparam int  OFFW       = 5 * RATIO;
  localparam int  ONW        = (3 + SETTLE) * RATIO;

  logic clk = 0, rst = 1;
  logic clk_125 = 0, clk_25 = 0, clk_2p5 = 0;
  logic rx_spd_10 = 0, rx_spd_100 = 0, rx_spd_1000 = 0, rx_link = 0;
  logic clk_tx, rst_tx, tx_spd_10, tx_spd_100, tx_spd_1000, link_up, changing;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #4   clk_125 = ~clk_125;
  always #20  clk_25  = ~clk_25;
  always #200 clk_2p5 = ~clk_2p5;

  txclk_select #(.STABLE_CYCLES(STABLE), .SLOW_RATIO(RATIO), .SETTLE_CLKS(SETTLE)) i_txclk_select (
    .clk(clk), .rst(rst), .clk_125(clk_125), .clk_25(clk_25), .clk_2p5(clk_2p5),
    .rx_spd_10(rx_spd_10), .rx_spd_100(rx_spd_100), .rx_spd_1000(rx_spd_1000),
    .rx_link(rx_link), .clk_tx(clk_tx), .rst_tx(rst_tx), .tx_spd_10(tx_spd_10),
    .tx_spd_100(tx_spd_100), .tx_spd_1000(tx_spd_1000), .link_up(link_up),
    .changing(changing)
  );

  int checks = 0, fails = 0;
  bit done = 0, cmp_en = 0, mon_on = 0, saw_chg = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---- behavioural reference model, updated on each system edge ----
  int m_sel, m_st, m_cnt, m_tgt, m_prev, m_run;
  int cd1, cd2, lk1, lk2;
  int m_rst, m_chg, m_lnk;

  function automatic int flag_code(bit a10, bit a100, bit a1000);
    if ({a1000, a100, a10} == 3'b001) return 0;
    if ({a1000, a100, a10} == 3'b010) return 1;
    if ({a1000, a100, a10} == 3'b100) return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      cd1 = 3; cd2 = 3; lk1 = 0; lk2 = 0;
      m_prev = 3; m_run = 1; m_sel = 2; m_st = 0; m_cnt = 0; m_tgt = 2;
      m_rst = 1; m_chg = 0; m_lnk = 0;
    end else begin
      int c, l;
      bit ok;
      c = cd2; l = lk2;
      ok = (c == m_prev) && (m_run >= STABLE);
      if (c != m_prev) begin m_prev = c; m_run = 1; end
      else if (m_run < 100000) m_run++;
      case (m_st)
        0: if (l != 0 && c != 3 && c != m_sel && ok) begin
             m_st = 1; m_cnt = 0; m_tgt = c;
           end
        1: if (m_cnt == OFFW - 1) begin m_sel = m_tgt; m_st = 2; m_cnt = 0; end
           else m_cnt++;
        default: if (m_cnt == ONW - 1) begin m_st = 0; m_cnt = 0; end
                 else m_cnt++;
      endcase
      m_rst = (m_st != 0 || l == 0) ? 1 : 0;
      m_chg = (m_st != 0) ? 1 : 0;
      m_lnk = l;
      cd2 = cd1; cd1 = flag_code(rx_spd_10, rx_spd_100, rx_spd_1000);
      lk2 = lk1; lk1 = rx_link;
    end
  end

  function automatic int spd_idx();
    if ({tx_spd_1000, tx_spd_100, tx_spd_10} == 3'b001) return 0;
    if ({tx_spd_1000, tx_spd_100, tx_spd_10} == 3'b010) return 1;
    if ({tx_spd_1000, tx_spd_100, tx_spd_10} == 3'b100) return 2;
    return 9;
  endfunction

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(spd_idx() == m_sel, "R1", "speed index", spd_idx(), m_sel);
      chk(int'(link_up) == m_lnk, "R2", "link_up", link_up, m_lnk);
      chk(int'(rst_tx) == m_rst, "R5", "rst_tx", rst_tx, m_rst);
      chk(int'(changing) == m_chg, "R7", "changing", changing, m_chg);
    end
    if (changing === 1'b1) saw_chg = 1;
  end

  // ---- edge timing of clk_tx ----
  realtime last_edge = 0, min_phase = 1.0e9;
  bit have_edge = 0;
  always @(posedge clk_tx or negedge clk_tx) begin
    if (mon_on) begin
      if (have_edge && ($realtime - last_edge) < min_phase) min_phase = $realtime - last_edge;
      last_edge = $realtime;
      have_edge = 1;
    end
  end

  task automatic set_in(bit l, bit a10, bit a100, bit a1000);
    @(negedge clk);
    rx_link = l; rx_spd_10 = a10; rx_spd_100 = a100; rx_spd_1000 = a1000;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic period_chk(real exp_ns);
    realtime t0, t1;
    @(posedge clk_tx); t0 = $realtime;
    @(posedge clk_tx); t1 = $realtime;
    chk((t1 - t0) > exp_ns - 0.5 && (t1 - t0) < exp_ns + 0.5, "R9", "clk_tx period ns",
        int'(t1 - t0), int'(exp_ns));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_cyc(2);
    cmp_en = 1;
    wait_cyc(30);
    // R10: reset state
    chk(rst_tx == 1 && changing == 0 && link_up == 0, "R10", "rst/chg/link",
        {rst_tx, changing, link_up}, 3'b100);
    chk(tx_spd_1000 == 1, "R10", "gigabit at reset", tx_spd_1000, 1);
    set_in(0, 0, 0, 1);
    rst = 0;
    wait_cyc(3);
    mon_on = 1;

    // link up at initial speed: reset releases, no changeover (R2, R5)
    set_in(1, 0, 0, 1);
    wait_cyc(40);
    chk(rst_tx == 0 && saw_chg == 0, "R5", "released without changeover", rst_tx, 0);
    period_chk(8.0);

    // move to 100 Mb (R7, R9)
    set_in(1, 0, 1, 0);
    wait_cyc(2 + STABLE + OFFW + ONW + 10);
    chk(tx_spd_100 == 1 && changing == 0 && rst_tx == 0, "R7", "at 100 after changeover",
        {tx_spd_1000, tx_spd_100, tx_spd_10}, 3'b010);
    period_chk(40.0);

    // short excursion: exactly STABLE cycles of 10 Mb, must be ignored (R3)
    saw_chg = 0;
    set_in(1, 1, 0, 0);
    wait_cyc(STABLE - 1);
    set_in(1, 0, 1, 0);
    wait_cyc(60);
    chk(saw_chg == 0 && tx_spd_100 == 1, "R3", "short excursion ignored", saw_chg, 0);

    // invalid patterns ignored (R4)
    set_in(1, 0, 1, 1);
    wait_cyc(80);
    chk(saw_chg == 0 && tx_spd_100 == 1, "R4", "two flags ignored", saw_chg, 0);
    set_in(1, 0, 0, 0);
    wait_cyc(80);
    chk(saw_chg == 0 && tx_spd_100 == 1, "R4", "no flags ignored", saw_chg, 0);

    // link down with a new stable speed: nothing moves (R6)
    set_in(0, 1, 0, 0);
    wait_cyc(400);
    chk(saw_chg == 0 && tx_spd_100 == 1, "R6", "held while link down", saw_chg, 0);
    chk(rst_tx == 1, "R6", "reset while link down", rst_tx, 1);

    // link returns: pending speed is applied (R6, R7, R9)
    set_in(1, 1, 0, 0);
    wait_cyc(4);
    chk(changing == 1, "R6", "changeover after link returns", changing, 1);
    wait_cyc(OFFW + ONW + 10);
    chk(tx_spd_10 == 1 && rst_tx == 0, "R1", "10 Mb selected", tx_spd_10, 1);
    period_chk(400.0);

    // back to gigabit (R1, R9)
    set_in(1, 0, 0, 1);
    wait_cyc(2 + STABLE + OFFW + ONW + 10);
    chk(tx_spd_1000 == 1 && rst_tx == 0, "R1", "gigabit selected", tx_spd_1000, 1);
    period_chk(8.0);

    // R8: runt phase check across all changeovers
    chk(min_phase > 3.9, "R8", "shortest clk_tx phase ps", int'(min_phase * 1000), 4000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule